// File: doc/BRIEF.md
# Sinusoidal PWM Duty Table Sequencer

This block chooses the duty word that each channel of a motor-drive channel group uses in every carrier period. All channels of the group share one table of duty words. On each pulse of the "next carrier period" input, the sequencer advances every channel through the table. The walk it follows depends on one of three wave shapes:

- **Full-wave** walks the table forward.
- **Half-wave** walks forward, then outputs zero.
- **Symmetric half-wave** walks forward, then walks back along the same entries, then outputs zero.

Each channel has its own starting table entry, and that entry sets its phase. Carrier counting, duty scaling, clamping and pin drive are done by blocks downstream, which take the per-channel duty words.

Configuration, starting phases and table contents are written into shadow storage. While the sequencer runs, that storage reaches the active copy only at the end of a full sine cycle, so the wave is never distorted. While the block is idle, the active copy follows the shadow every clock.

Top module: `spwm_table_seq`

## Requirements
- R1: After reset the duty outputs and `cycle_end` are 0. The table holds zeros and every starting phase is 0. The configuration is full-wave with a modulation index equal to the table depth (64).
- R2: In full-wave mode (`cfg_mode`=2) with index N (1..64), period p of the sine cycle outputs table entry (s+p) mod N, where s is the channel's start. The cycle repeats after N periods.
- R3: In half-wave mode (`cfg_mode`=1) with index N (1..128), let L = floor(N/2). Periods 0..L-1 output entry (s+p) mod L, and the remaining N-L periods output 0.
- R4: In symmetric mode (`cfg_mode`=0) with index N (1..256), let Q = floor(N/4). Periods 0..Q-1 output entry (s+p) mod Q. Periods Q..2Q-1 output entry (s+Q-1-k) mod Q with k = p-Q. The remaining N-2Q periods output 0.
- R5: A configuration write is ignored if it has mode 3, index 0, or an index above the mode's limit (64 full, 128 half, 256 symmetric).
- R6: A phase write with `ph_all`=1 sets every channel's start. With `ph_all`=0 it sets only channel `ph_ch`. A start at or beyond the used length (N, L or Q) is taken as 0.
- R7: While the block is running, table, configuration and phase writes leave the output unchanged until the sine cycle ends. From the first period of the next cycle the new settings apply.
- R8: `cycle_end` is high, combinationally, during the `carrier_tick` cycle that closes period N-1. The next period is period 0 of a new cycle.
- R9: While `run` is low, every duty output is 0 and `carrier_tick` has no effect. One clock after `run` rises, period 0 is shown.
- R10: Between ticks, every duty output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Sequencer enable; low stops and clears the position |
| carrier_tick | input | 1 | One-clock pulse ending the current carrier period |
| tbl_we | input | 1 | Shadow table write strobe |
| tbl_addr | input | 6 | Shadow table entry |
| tbl_data | input | 16 | Duty word to store |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | 0 symmetric half-wave, 1 half-wave, 2 full-wave |
| cfg_nidx | input | 9 | Modulation index N (periods per sine cycle) |
| ph_we | input | 1 | Starting phase write strobe |
| ph_all | input | 1 | 1 writes every channel, 0 writes channel `ph_ch` only |
| ph_ch | input | 2 | Channel selected for a single-channel phase write |
| ph_val | input | 6 | Starting table entry |
| duty_out | output | 64 | Per-channel duty words, channel c in bits [16c+15:16c] |
| cycle_end | output | 1 | High during the tick that completes a sine cycle |

## Verification
The hardest situation to reach is a shadow write that lands mid-cycle. The stale active entry and the new shadow entry must both be observable from the ports. To set this up, the stimulus overwrites a table entry that the current cycle has not yet reached, and changes mode, index and phase together. It then checks that the old value is still shown in that period, and that the new value first appears on the right period of the next cycle. Odd modulation indices, and starts beyond the used length, drive the remainder-to-zero and clamp-to-zero rules. An index of 256 in symmetric mode exercises the position counter at full range.

// File: rtl/spwm_seq_pkg.sv
`timescale 1ns/1ps
package spwm_seq_pkg;

    typedef enum logic [1:0] {
        WM_SYM  = 2'd0,
        WM_HALF = 2'd1,
        WM_FULL = 2'd2
    } wave_mode_e;

    typedef enum logic [1:0] {
        SEG_FWD  = 2'd0,
        SEG_MIR  = 2'd1,
        SEG_ZERO = 2'd2
    } seg_e;

    typedef enum logic [1:0] {
        STP_HOLD = 2'd0,
        STP_INC  = 2'd1,
        STP_DEC  = 2'd2,
        STP_LOAD = 2'd3
    } step_e;

    // Largest accepted modulation index for a mode; 0 marks an illegal mode.
    function automatic int unsigned mode_limit(input logic [1:0] m, input int unsigned depth);
        case (m)
            2'd2:    return depth;
            2'd1:    return 2 * depth;
            2'd0:    return 4 * depth;
            default: return 0;
        endcase
    endfunction

    // Number of table entries one sine cycle walks through.
    function automatic int unsigned len_of(input logic [1:0] m, input int unsigned n);
        case (m)
            2'd2:    return n;
            2'd1:    return n >> 1;
            2'd0:    return n >> 2;
            default: return 0;
        endcase
    endfunction

    // Segment of the sine cycle that position p falls into.
    function automatic seg_e seg_of(input logic [1:0] m, input int unsigned p,
                                    input int unsigned len);
        if (m == 2'd2)                 return SEG_FWD;
        if (p < len)                   return SEG_FWD;
        if (m == 2'd0 && p < 2 * len)  return SEG_MIR;
        return SEG_ZERO;
    endfunction

endpackage

// File: rtl/spwm_cfg_shadow.sv
`timescale 1ns/1ps
module spwm_cfg_shadow
    import spwm_seq_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int TBL_DEPTH = 64,
    parameter int AW        = 6,
    parameter int NIDX_W    = 9,
    parameter int LEN_W     = 7,
    parameter int CH_W      = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_we,
    input  logic [1:0]                 cfg_mode,
    input  logic [NIDX_W-1:0]          cfg_nidx,
    input  logic                       ph_we,
    input  logic                       ph_all,
    input  logic [CH_W-1:0]            ph_ch,
    input  logic [AW-1:0]              ph_val,
    input  logic                       load,
    output logic [1:0]                 act_mode,
    output logic [NIDX_W-1:0]          act_nidx,
    output logic [LEN_W-1:0]           act_len,
    output logic [NUM_CH-1:0][AW-1:0]  ld_start
);

    logic [1:0]                sh_mode;
    logic [NIDX_W-1:0]         sh_nidx;
    logic [LEN_W-1:0]          sh_len;
    logic [NUM_CH-1:0][AW-1:0] sh_start;
    logic                      cfg_ok;

    always_comb begin
        cfg_ok = (cfg_mode != 2'd3) && (cfg_nidx != '0) &&
                 (32'(cfg_nidx) <= mode_limit(cfg_mode, 32'(TBL_DEPTH)));
        sh_len = LEN_W'(len_of(sh_mode, 32'(sh_nidx)));
        for (int c = 0; c < NUM_CH; c++) begin
            ld_start[c] = (LEN_W'(sh_start[c]) >= sh_len) ? '0 : sh_start[c];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_mode <= WM_FULL;
            sh_nidx <= NIDX_W'(TBL_DEPTH);
        end else if (cfg_we && cfg_ok) begin
            sh_mode <= cfg_mode;
            sh_nidx <= cfg_nidx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_start <= '0;
        end else if (ph_we) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (ph_all || ph_ch == CH_W'(c)) sh_start[c] <= ph_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_mode <= WM_FULL;
            act_nidx <= NIDX_W'(TBL_DEPTH);
            act_len  <= LEN_W'(TBL_DEPTH);
        end else if (load) begin
            act_mode <= sh_mode;
            act_nidx <= sh_nidx;
            act_len  <= sh_len;
        end
    end

endmodule

// File: rtl/spwm_duty_table.sv
`timescale 1ns/1ps
module spwm_duty_table #(
    parameter int TBL_DEPTH = 64,
    parameter int DUTY_W    = 16,
    parameter int AW        = 6,
    parameter int NUM_CH    = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we,
    input  logic [AW-1:0]                  waddr,
    input  logic [DUTY_W-1:0]              wdata,
    input  logic                           load,
    input  logic [NUM_CH-1:0][AW-1:0]      rd_idx,
    output logic [NUM_CH-1:0][DUTY_W-1:0]  rd_data
);

    logic [DUTY_W-1:0] sh_tbl  [TBL_DEPTH];
    logic [DUTY_W-1:0] act_tbl [TBL_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TBL_DEPTH; i++) sh_tbl[i] <= '0;
        end else if (we) begin
            sh_tbl[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TBL_DEPTH; i++) act_tbl[i] <= '0;
        end else if (load) begin
            for (int i = 0; i < TBL_DEPTH; i++) act_tbl[i] <= sh_tbl[i];
        end
    end

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) rd_data[c] = act_tbl[rd_idx[c]];
    end

endmodule

// File: rtl/spwm_cycle_ctrl.sv
`timescale 1ns/1ps
module spwm_cycle_ctrl
    import spwm_seq_pkg::*;
#(
    parameter int NIDX_W = 9,
    parameter int POS_W  = 8,
    parameter int LEN_W  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              tick,
    input  logic [1:0]        act_mode,
    input  logic [NIDX_W-1:0] act_nidx,
    input  logic [LEN_W-1:0]  act_len,
    output logic              running,
    output seg_e              seg,
    output step_e             step,
    output logic              load,
    output logic              cycle_end,
    output logic [POS_W-1:0]  pos
);

    logic [NIDX_W-1:0] pos_w;
    logic [NIDX_W-1:0] nxt_w;
    seg_e              nxt_seg;

    always_comb begin
        pos_w     = NIDX_W'(pos);
        nxt_w     = pos_w + NIDX_W'(1);
        seg       = seg_of(act_mode, 32'(pos_w), 32'(act_len));
        nxt_seg   = seg_of(act_mode, 32'(nxt_w), 32'(act_len));
        cycle_end = running && run && tick && (pos_w == act_nidx - NIDX_W'(1));
        load      = !running || cycle_end;

        step = STP_HOLD;
        if (load) begin
            step = STP_LOAD;
        end else if (run && tick) begin
            case (nxt_seg)
                SEG_FWD: step = STP_INC;
                SEG_MIR: step = (seg == SEG_MIR) ? STP_DEC : STP_HOLD;
                default: step = STP_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            pos     <= '0;
        end else begin
            running <= run;
            if (!running || !run || cycle_end) pos <= '0;
            else if (tick)                     pos <= pos + POS_W'(1);
        end
    end

endmodule

// File: rtl/spwm_chan_walker.sv
`timescale 1ns/1ps
module spwm_chan_walker
    import spwm_seq_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  step_e            step,
    input  logic [AW-1:0]    ld_start,
    input  logic [LEN_W-1:0] len,
    output logic [AW-1:0]    idx
);

    logic [LEN_W-1:0] inc_w;

    always_comb inc_w = LEN_W'(idx) + LEN_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else begin
            case (step)
                STP_LOAD: idx <= ld_start;
                STP_INC:  idx <= (inc_w >= len) ? '0 : AW'(inc_w);
                STP_DEC:  idx <= (idx == '0) ? AW'(len - LEN_W'(1)) : idx - AW'(1);
                default:  idx <= idx;
            endcase
        end
    end

endmodule

// File: rtl/spwm_table_seq.sv
`timescale 1ns/1ps
module spwm_table_seq
    import spwm_seq_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int DUTY_W    = 16,
    parameter int TBL_DEPTH = 64,
    localparam int AW       = $clog2(TBL_DEPTH),
    localparam int NIDX_W   = $clog2(4 * TBL_DEPTH + 1),
    localparam int POS_W    = $clog2(4 * TBL_DEPTH),
    localparam int LEN_W    = $clog2(TBL_DEPTH + 1),
    localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       run,
    input  logic                       carrier_tick,
    input  logic                       tbl_we,
    input  logic [AW-1:0]              tbl_addr,
    input  logic [DUTY_W-1:0]          tbl_data,
    input  logic                       cfg_we,
    input  logic [1:0]                 cfg_mode,
    input  logic [NIDX_W-1:0]          cfg_nidx,
    input  logic                       ph_we,
    input  logic                       ph_all,
    input  logic [CH_W-1:0]            ph_ch,
    input  logic [AW-1:0]              ph_val,
    output logic [NUM_CH*DUTY_W-1:0]   duty_out,
    output logic                       cycle_end
);

    logic [1:0]                    act_mode;
    logic [NIDX_W-1:0]             act_nidx;
    logic [LEN_W-1:0]              act_len;
    logic [NUM_CH-1:0][AW-1:0]     ld_start;
    logic [NUM_CH-1:0][AW-1:0]     ch_idx;
    logic [NUM_CH-1:0][DUTY_W-1:0] rd_data;
    logic                          running;
    logic                          load;
    logic [POS_W-1:0]              pos;
    seg_e                          seg_cur;
    step_e                         step;

    spwm_cfg_shadow #(
        .NUM_CH(NUM_CH), .TBL_DEPTH(TBL_DEPTH), .AW(AW),
        .NIDX_W(NIDX_W), .LEN_W(LEN_W), .CH_W(CH_W)
    ) u_cfg (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_nidx(cfg_nidx),
        .ph_we(ph_we), .ph_all(ph_all), .ph_ch(ph_ch), .ph_val(ph_val),
        .load(load),
        .act_mode(act_mode), .act_nidx(act_nidx), .act_len(act_len),
        .ld_start(ld_start)
    );

    spwm_duty_table #(
        .TBL_DEPTH(TBL_DEPTH), .DUTY_W(DUTY_W), .AW(AW), .NUM_CH(NUM_CH)
    ) u_tbl (
        .clk(clk), .rst(rst),
        .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_data),
        .load(load), .rd_idx(ch_idx), .rd_data(rd_data)
    );

    spwm_cycle_ctrl #(
        .NIDX_W(NIDX_W), .POS_W(POS_W), .LEN_W(LEN_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .run(run), .tick(carrier_tick),
        .act_mode(act_mode), .act_nidx(act_nidx), .act_len(act_len),
        .running(running), .seg(seg_cur), .step(step), .load(load),
        .cycle_end(cycle_end), .pos(pos)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        spwm_chan_walker #(
            .AW(AW), .LEN_W(LEN_W)
        ) u_walk (
            .clk(clk), .rst(rst), .step(step),
            .ld_start(ld_start[c]), .len(act_len), .idx(ch_idx[c])
        );

        always_comb begin
            duty_out[c*DUTY_W +: DUTY_W] =
                (running && seg_cur != SEG_ZERO) ? rd_data[c] : '0;
        end
    end

endmodule

// File: rtl/spwm_seq_chk.sv
`timescale 1ns/1ps
module spwm_seq_chk
    import spwm_seq_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int DUTY_W    = 16,
    parameter int TBL_DEPTH = 64,
    parameter int NIDX_W    = 9,
    parameter int POS_W     = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     run,
    input logic                     carrier_tick,
    input logic                     running,
    input logic                     cycle_end,
    input seg_e                     seg,
    input logic [POS_W-1:0]         pos,
    input logic [1:0]               act_mode,
    input logic [NIDX_W-1:0]        act_nidx,
    input logic [NUM_CH*DUTY_W-1:0] duty_out
);

    localparam int LW = NIDX_W + 1;
    logic [LW-1:0] lim;

    always_comb begin
        case (act_mode)
            2'd0:    lim = LW'(4 * TBL_DEPTH);
            2'd1:    lim = LW'(2 * TBL_DEPTH);
            2'd2:    lim = LW'(TBL_DEPTH);
            default: lim = '0;
        endcase
    end

    AST_ZERO_SEG_QUIET: assert property (@(posedge clk) disable iff (rst)
        seg == SEG_ZERO |-> duty_out == '0); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !running |-> (duty_out == '0 && !cycle_end)); // R9
    AST_END_WRAPS: assert property (@(posedge clk) disable iff (rst)
        cycle_end |=> pos == '0); // R8
    AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        running |-> LW'(pos) < LW'(act_nidx)); // R8
    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
        (running && run && !carrier_tick) |=> $stable(duty_out)); // R10
    AST_ACTIVE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (act_nidx != '0 && LW'(act_nidx) <= lim)); // R5

endmodule

bind spwm_table_seq spwm_seq_chk #(
    .NUM_CH(NUM_CH), .DUTY_W(DUTY_W), .TBL_DEPTH(TBL_DEPTH),
    .NIDX_W(NIDX_W), .POS_W(POS_W)
) u_chk (
    .clk(clk), .rst(rst), .run(run), .carrier_tick(carrier_tick),
    .running(running), .cycle_end(cycle_end), .seg(seg_cur), .pos(pos),
    .act_mode(act_mode), .act_nidx(act_nidx), .duty_out(duty_out)
);

// File: tb/sim_spwm_table_seq.sv
`timescale 1ns/1ps
module sim_spwm_table_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        tick = 1'b0;
    logic        tbl_we = 1'b0;
    logic [5:0]  tbl_addr = '0;
    logic [15:0] tbl_data = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_mode = '0;
    logic [8:0]  cfg_nidx = '0;
    logic        ph_we = 1'b0;
    logic        ph_all = 1'b0;
    logic [1:0]  ph_ch = '0;
    logic [5:0]  ph_val = '0;
    logic [63:0] duty;
    logic        cycle_end;

    int n_chk = 0;
    int n_bad = 0;
    int tb_tbl [64];
    int st [4];

    always #2.5 clk = ~clk;

    spwm_table_seq u0 (
        .clk(clk), .rst(rst), .run(run), .carrier_tick(tick),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_nidx(cfg_nidx),
        .ph_we(ph_we), .ph_all(ph_all), .ph_ch(ph_ch), .ph_val(ph_val),
        .duty_out(duty), .cycle_end(cycle_end)
    );

    typedef struct packed {
        logic [1:0] m;
        logic [8:0] n;
        logic [5:0] b;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'd2, 9'd10,  6'd0},
        '{2'd2, 9'd64,  6'd5},
        '{2'd2, 9'd7,   6'd3},
        '{2'd1, 9'd10,  6'd2},
        '{2'd1, 9'd128, 6'd40},
        '{2'd1, 9'd9,   6'd1},
        '{2'd0, 9'd16,  6'd1},
        '{2'd0, 9'd256, 6'd10},
        '{2'd0, 9'd11,  6'd2},
        '{2'd2, 9'd1,   6'd0},
        '{2'd0, 9'd3,   6'd0}
    };

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_entry(int m, int n, int s, int p);
        int len;
        len = (m == 2) ? n : (m == 1) ? n / 2 : n / 4;
        if (s >= len) s = 0;
        if (p < len) return (s + p) % len;
        if (m == 0 && p < 2 * len) return (s + len - 1 - (p - len)) % len;
        return -1;
    endfunction

    task automatic chk_duty(int m, int n, string req, int p);
        for (int c = 0; c < 4; c++) begin
            int e;
            int ev;
            int av;
            e  = exp_entry(m, n, st[c], p);
            ev = (e < 0) ? 0 : tb_tbl[e];
            av = int'(duty[c*16 +: 16]);
            chk(av == ev, req, av, ev);
        end
    endtask

    task automatic chk_zero(string req);
        chk(duty == '0, req, duty, 0);
    endtask

    task automatic wr_cfg(int m, int n);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = 2'(m); cfg_nidx = 9'(n);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_ph(bit all, int ch, int v);
        @(negedge clk);
        ph_we = 1'b1; ph_all = all; ph_ch = 2'(ch); ph_val = 6'(v);
        @(negedge clk);
        ph_we = 1'b0; ph_all = 1'b0;
    endtask

    task automatic wr_tbl(int a, int d);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = 6'(a); tbl_data = 16'(d);
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic go();
        run = 1'b1;
        @(negedge clk);
    endtask

    task automatic stop();
        run = 1'b0;
        @(negedge clk);
    endtask

    task automatic tick_once(bit exp_end);
        tick = 1'b1;
        #1;
        chk(cycle_end == exp_end, "R8 cycle_end", cycle_end, exp_end);
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic run_cycles(int m, int n, int periods, string req);
        chk_duty(m, n, req, 0);
        for (int p = 0; p < periods; p++) begin
            tick_once((p % n) == n - 1);
            chk_duty(m, n, req, (p + 1) % n);
            @(negedge clk);
            chk_duty(m, n, "R10", (p + 1) % n);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) tb_tbl[i] = 0;
        for (int c = 0; c < 4; c++) st[c] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state, table cleared
        chk_zero("R1 duty after reset");
        chk(cycle_end == 1'b0, "R1 cycle_end after reset", cycle_end, 0);
        tick = 1'b1;
        #1;
        chk(cycle_end == 1'b0, "R9 tick while idle", cycle_end, 0);
        @(negedge clk);
        tick = 1'b0;
        go();
        chk_zero("R1 table cleared");
        stop();

        // Load table while idle
        for (int i = 0; i < 64; i++) begin
            tb_tbl[i] = 16'h1000 + i * 16'h0111;
            wr_tbl(i, tb_tbl[i]);
        end
        // R1: default full-wave, index 64, start 0
        go();
        run_cycles(2, 64, 65, "R1 default config");
        stop();
        chk_zero("R9 stopped");

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            int m;
            int n;
            string req;
            m = int'(VECS[i].m);
            n = int'(VECS[i].n);
            req = (m == 2) ? "R2" : (m == 1) ? "R3" : "R4";
            wr_cfg(m, n);
            for (int c = 0; c < 4; c++) begin
                st[c] = (int'(VECS[i].b) + 5 * c) % 64;
                wr_ph(1'b0, c, st[c]);
            end
            go();
            run_cycles(m, n, n + 2, req);
            stop();
            chk_zero("R9 stopped");
        end

        // R5: illegal configurations ignored
        wr_cfg(2, 8);
        wr_cfg(2, 65);
        wr_cfg(3, 8);
        wr_cfg(1, 0);
        wr_cfg(1, 129);
        wr_ph(1'b1, 0, 0);
        for (int c = 0; c < 4; c++) st[c] = 0;
        go();
        run_cycles(2, 8, 9, "R5 rejected write");
        stop();

        // R6: broadcast, single-channel and out-of-range starts
        wr_cfg(2, 10);
        wr_ph(1'b1, 0, 4);
        wr_ph(1'b0, 2, 40);
        wr_ph(1'b0, 1, 9);
        st[0] = 4; st[1] = 9; st[2] = 40; st[3] = 4;
        go();
        run_cycles(2, 10, 3, "R6 phase");
        stop();

        // R7: mid-cycle writes deferred to cycle end
        wr_cfg(2, 8);
        wr_ph(1'b1, 0, 2);
        for (int c = 0; c < 4; c++) st[c] = 2;
        go();
        chk_duty(2, 8, "R7 p0", 0);
        tick_once(1'b0);
        wr_tbl(3, 16'hBEEF);
        wr_cfg(1, 8);
        wr_ph(1'b1, 0, 1);
        chk_duty(2, 8, "R7 old table entry", 1);
        for (int p = 1; p < 7; p++) begin
            tick_once(1'b0);
            chk_duty(2, 8, "R7 old config", p + 1);
        end
        tick_once(1'b1);
        tb_tbl[3] = 16'hBEEF;
        for (int c = 0; c < 4; c++) st[c] = 1;
        chk_duty(1, 8, "R7 new config", 0);
        for (int p = 0; p < 8; p++) begin
            tick_once(p == 7);
            chk_duty(1, 8, "R7 new cycle", (p + 1) % 8);
        end

        // R9: stop mid-cycle and restart at period 0
        tick_once(1'b0);
        tick_once(1'b0);
        stop();
        chk_zero("R9 stop mid-cycle");
        go();
        chk_duty(1, 8, "R9 restart", 0);
        stop();

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule